// File: doc/BRIEF.md
# Configurable-width serial transmitter

This block turns data words into frames on an asynchronous serial line. When a word is waiting at its input and no frame is in progress, it takes the word with a one-cycle pop strobe. It then sends a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. The length of a character can be anything from 5 to 16 bits. Parity can be odd, even, a constant one (mark) or a constant zero (space).

Bit timing comes from a reference tick that pulses at a fixed rate. A divisor sets how many reference ticks make one bit time. A separate control bit forces the line to the spacing level (break). A loopback select moves the frame from the external line onto an internal return path. Two status outputs tell software whether the input word slot is empty and whether the whole transmitter is empty.

The frame format, the divisor and the word are all captured when the word is popped. A host can therefore reprogram the next frame while the current one is still being sent. The FIFO storage and the host register decoding are outside this block.

Top module: `wordser_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is off, both `tx_line` and `loop_line` are 1.
- R2: A frame is one start bit at 0, then the data bits least significant bit first, then the parity bit if parity is enabled, then the stop bits at 1.
- R3: `line_ctrl[3:0]` sets the number of data bits. A value of 0 means 16 bits. Values 1 to 4 mean 5 bits. Values 5 to 15 mean that many bits. Word bits above the selected length are not sent.
- R4: `line_ctrl[4]` selects the stop bits: 0 gives one stop bit and 1 gives two.
- R5: `line_ctrl[7:5]` selects parity. Code 0 means no parity bit. Code 1 is odd parity and code 2 is even parity, both taken over the bits actually sent. Code 5 sends a constant 1 and code 7 sends a constant 0. Codes 3, 4 and 6 mean no parity bit.
- R6: Each bit lasts `divisor` reference ticks, and a divisor of 0 counts as 1. The first of these ticks is the first reference tick after the pop cycle.
- R7: `fifo_pop` is high for one cycle, only while `fifo_valid` is high and no frame is in progress. The start bit appears on the cycle after the pop. While a frame is in progress, no pop occurs.
- R8: The frame fields and the divisor are captured at the pop. Changing them during a frame affects only later frames.
- R9: While `line_ctrl[8]` is 1, the active serial output is 0 immediately, whatever the frame state.
- R10: `thr_empty` is the inverse of `fifo_valid`. `all_empty` is 1 only when `thr_empty` is 1 and no frame is in progress.
- R11: With `loop_sel` at 1, the frame appears on `loop_line` and `tx_line` stays 1. With `loop_sel` at 0, the frame appears on `tx_line` and `loop_line` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | Reference rate pulse, one clock wide |
| line_ctrl | input | 9 | Frame format: length [3:0], stop select [4], parity code [7:5], break [8] |
| divisor | input | 16 | Reference ticks per bit; 0 counts as 1 |
| fifo_data | input | 16 | Word at the head of the transmit FIFO |
| fifo_valid | input | 1 | A word is available at `fifo_data` |
| loop_sel | input | 1 | Route the frame to `loop_line` instead of `tx_line` |
| tx_line | output | 1 | External serial output, idles at 1 |
| loop_line | output | 1 | Internal loopback serial output, idles at 1 |
| fifo_pop | output | 1 | One-cycle strobe: the word has been taken |
| thr_empty | output | 1 | No word is waiting at the input |
| all_empty | output | 1 | No word is waiting and no frame is in progress |

## Verification
The hardest case to reach from the ports is a change of format and divisor while a frame is being sent, with the next word already offered. In that case the running frame must keep its old settings and the new word must not be popped early. The driver reaches this state by reprogramming `line_ctrl` and `divisor` on the cycle after a pop and raising `fifo_valid` straight away. The scoreboard records each frame's settings at the pop, so a frame that picks up the new settings, or a premature pop, shows up as a miscompare. Reference ticks arrive every third clock, so the bench also sees how the start bit lines up with a tick phase that is not in step with the pop.

// File: rtl/wtx_pkg.sv
// Shared types for the serial transmitter.
// Assumes: no frame has more than 255 data bits, which fits the 8-bit count field.
package wtx_pkg;

    localparam int CFG_NB_W = 8;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_EVEN  = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd5;
    localparam logic [2:0] PAR_SPACE = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef struct packed {
        logic [CFG_NB_W-1:0] nbits;
        logic                par_en;
        logic                par_bit;
        logic                two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/wtx_cfg_decode.sv
// Decodes the frame fields of the line-control word, together with the
// offered data word, into a per-frame configuration.
// Assumes: ctrl holds length [LEN_W-1:0], stop select [LEN_W] and
// parity code [LEN_W+3:LEN_W+1]. Purely combinational.
module wtx_cfg_decode
    import wtx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 5,
    localparam int FLD_W  = LEN_W + 4
) (
    input  logic [FLD_W-1:0]  ctrl,
    input  logic [DATA_W-1:0] data,
    output frame_cfg_t        cfg
);

    localparam int STOP_POS = LEN_W;
    localparam int PAR_LO   = LEN_W + 1;

    logic [LEN_W-1:0]    len_field;
    logic [2:0]          par_code;
    logic [CFG_NB_W-1:0] nbits;
    logic [DATA_W-1:0]   keep_mask;
    logic                odd_ones;

    assign len_field = ctrl[LEN_W-1:0];
    assign par_code  = ctrl[PAR_LO+2:PAR_LO];

    // Map the length field to an actual bit count: 0 -> full word, clamp short and long values
    always_comb begin
        if (len_field == '0)
            nbits = CFG_NB_W'(DATA_W);
        else if (len_field < LEN_W'(MIN_LEN))
            nbits = CFG_NB_W'(MIN_LEN);
        else if (CFG_NB_W'(len_field) > CFG_NB_W'(DATA_W))
            nbits = CFG_NB_W'(DATA_W);
        else
            nbits = CFG_NB_W'(len_field);
    end

    // One mask bit per data position, set where that position is sent
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign keep_mask[i] = (nbits > CFG_NB_W'(i));
    end

    assign odd_ones = ^(data & keep_mask);

    // Select the parity bit and its enable from the parity code
    always_comb begin
        cfg.nbits    = nbits;
        cfg.two_stop = ctrl[STOP_POS];
        cfg.par_en   = 1'b1;
        cfg.par_bit  = 1'b0;
        case (par_code)
            PAR_ODD:   cfg.par_bit = ~odd_ones;
            PAR_EVEN:  cfg.par_bit = odd_ones;
            PAR_MARK:  cfg.par_bit = 1'b1;
            PAR_SPACE: cfg.par_bit = 1'b0;
            default:   cfg.par_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/wtx_baud_gen.sv
// Bit-time generator: counts reference ticks and pulses bit_tick at the end
// of every bit time while a frame runs.
// Assumes: restart comes on the pop cycle. The divisor is captured there,
// and a divisor of 0 is taken as 1.
module wtx_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div,
    output logic             bit_tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic             at_last;

    assign at_last  = (cnt == div_q - DIV_W'(1));
    assign bit_tick = run & ref_tick & at_last;

    // Capture the divisor at the pop and count reference ticks within a bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= DIV_W'(1);
        end else if (restart) begin
            cnt   <= '0;
            div_q <= (div == '0) ? DIV_W'(1) : div;
        end else if (run && ref_tick) begin
            cnt <= at_last ? '0 : cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/wtx_shifter.sv
// Frame sequencer: takes a word when idle and steps through the start, data,
// parity and stop bits, one state change per bit_tick.
// Assumes: cfg_in belongs to word_data on the cycle the word is taken.
module wtx_shifter
    import wtx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  frame_cfg_t        cfg_in,
    input  logic              bit_tick,
    output logic              load,
    output logic              busy,
    output logic              frame_bit
);

    tx_state_e           state;
    logic [DATA_W-1:0]   shreg;
    logic [CFG_NB_W-1:0] bitcnt;
    frame_cfg_t          cfg_q;

    assign load = (state == ST_IDLE) & word_valid;
    assign busy = (state != ST_IDLE);

    // Advance through the frame on each bit tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            cfg_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (word_valid) begin
                    state  <= ST_START;
                    shreg  <= word_data;
                    cfg_q  <= cfg_in;
                    bitcnt <= '0;
                end
                ST_START: if (bit_tick) state <= ST_DATA;
                ST_DATA: if (bit_tick) begin
                    shreg  <= shreg >> 1;
                    bitcnt <= bitcnt + CFG_NB_W'(1);
                    if (bitcnt == cfg_q.nbits - CFG_NB_W'(1))
                        state <= cfg_q.par_en ? ST_PARITY : ST_STOP1;
                end
                ST_PARITY: if (bit_tick) state <= ST_STOP1;
                ST_STOP1: if (bit_tick) state <= cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2: if (bit_tick) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line level for the current frame position
    always_comb begin
        case (state)
            ST_START:  frame_bit = 1'b0;
            ST_DATA:   frame_bit = shreg[0];
            ST_PARITY: frame_bit = cfg_q.par_bit;
            default:   frame_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/wordser_tx.sv
// Top of the serial transmitter: format decode, bit timing, frame sequencing,
// break forcing and loopback routing.
// Assumes: line_ctrl holds length, stop select, parity code and break, from
// the least significant bit up. ref_tick is one clock wide.
module wordser_tx
    import wtx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 16,
    parameter int MIN_LEN = 5,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int CTRL_W = LEN_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [CTRL_W-1:0] line_ctrl,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_valid,
    input  logic              loop_sel,
    output logic              tx_line,
    output logic              loop_line,
    output logic              fifo_pop,
    output logic              thr_empty,
    output logic              all_empty
);

    localparam int BRK_POS = LEN_W + 4;

    frame_cfg_t cfg_next;
    logic       bit_tick;
    logic       busy;
    logic       frame_bit;
    logic       brk_en;
    logic       line_lvl;

    wtx_cfg_decode #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN)
    ) u_decode (
        .ctrl(line_ctrl[BRK_POS-1:0]),
        .data(fifo_data),
        .cfg (cfg_next)
    );

    wtx_baud_gen #(
        .DIV_W(DIV_W)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fifo_pop),
        .run     (busy),
        .ref_tick(ref_tick),
        .div     (divisor),
        .bit_tick(bit_tick)
    );

    wtx_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_valid(fifo_valid),
        .word_data (fifo_data),
        .cfg_in    (cfg_next),
        .bit_tick  (bit_tick),
        .load      (fifo_pop),
        .busy      (busy),
        .frame_bit (frame_bit)
    );

    // Break overrides the frame level; loopback picks which output carries it
    assign brk_en    = line_ctrl[BRK_POS];
    assign line_lvl  = frame_bit & ~brk_en;
    assign tx_line   = loop_sel ? 1'b1 : line_lvl;
    assign loop_line = loop_sel ? line_lvl : 1'b1;

    // Status flags
    assign thr_empty = ~fifo_valid;
    assign all_empty = ~fifo_valid & ~busy;

endmodule

// File: rtl/wordser_tx_chk.sv
// Property checker for the serial transmitter, attached by bind below.
// Assumes: brk follows the break bit of the line-control word.
module wordser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_valid,
    input logic fifo_pop,
    input logic thr_empty,
    input logic all_empty,
    input logic brk,
    input logic loop_sel,
    input logic tx_line,
    input logic loop_line
);

    logic act_line;
    assign act_line = loop_sel ? loop_line : tx_line;

    // R7
    pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_valid);

    // R7
    no_repeat_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R10
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> thr_empty);

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_empty && !brk) |-> act_line);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (brk || !act_line));

    // R11
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_sel |-> tx_line);

endmodule

bind wordser_tx wordser_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_valid(fifo_valid),
    .fifo_pop  (fifo_pop),
    .thr_empty (thr_empty),
    .all_empty (all_empty),
    .brk       (brk_en),
    .loop_sel  (loop_sel),
    .tx_line   (tx_line),
    .loop_line (loop_line)
);

// File: tb/wordser_tx_tb_top.sv
// Scoreboard bench: the driver queues each expected frame at its pop, and a
// monitor decodes the serial output and compares it with the queue head.
module wordser_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int REF_DIV    = 3;
    localparam int WDOG_LIMIT = 60000;

    typedef struct {
        logic [15:0] data;
        logic [8:0]  lcr;
        int          div;
        bit          loop;
        string       tag;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ref_tick = 0;
    logic [8:0]  line_ctrl = '0;
    logic [15:0] divisor = 16'd1;
    logic [15:0] fifo_data = '0;
    logic        fifo_valid = 0;
    logic        loop_sel = 0;
    logic        tx_line, loop_line, fifo_pop, thr_empty, all_empty;

    int vectors = 0;
    int miscompares = 0;

    item_t exp_q[$];

    wordser_tx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .line_ctrl (line_ctrl),
        .divisor   (divisor),
        .fifo_data (fifo_data),
        .fifo_valid(fifo_valid),
        .loop_sel  (loop_sel),
        .tx_line   (tx_line),
        .loop_line (loop_line),
        .fifo_pop  (fifo_pop),
        .thr_empty (thr_empty),
        .all_empty (all_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [8:0] mk_lcr(input int len, input bit two_stop,
                                          input logic [2:0] par, input bit brk);
        return {brk, par, two_stop, 4'(len)};
    endfunction

    // Expected frame bit i is the level of bit time i (R2..R5)
    function automatic void compose(input item_t it, output logic [31:0] bits,
                                    output int nb);
        int n;
        int ones;
        int p;
        n = int'(it.lcr[3:0]);
        if (n == 0) n = 16;
        else if (n < 5) n = 5;
        bits = '1;
        bits[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            bits[1+i] = it.data[i];
            if (it.data[i]) ones++;
        end
        nb = 1 + n;
        p = int'(it.lcr[7:5]);
        if (p == 1 || p == 2 || p == 5 || p == 7) begin
            if (p == 1) bits[nb] = (ones % 2 == 0);
            else if (p == 2) bits[nb] = (ones % 2 == 1);
            else bits[nb] = (p == 5);
            nb++;
        end
        nb += it.lcr[4] ? 2 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor and reference tick generator share one process so that each
    // negedge sees the tick value the design used at the preceding posedge
    bit          mon_on = 0;
    bit          mon_bad = 0;
    int          tcount = 0;
    int          nb_cur = 0;
    int          rc = 0;
    item_t       cur;
    logic [31:0] exp_bits;
    logic [31:0] got_bits;

    task automatic sample_bit(input int idx);
        logic obs;
        obs = cur.loop ? loop_line : tx_line;
        got_bits[idx] = obs;
        if (obs !== exp_bits[idx]) mon_bad = 1;
        if (cur.loop ? (tx_line !== 1'b1) : (loop_line !== 1'b1)) mon_bad = 1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_on) begin
                if (ref_tick) begin
                    tcount++;
                    if (tcount % cur.div == 0) begin
                        sample_bit(tcount / cur.div);
                        if (tcount / cur.div == nb_cur - 1) begin
                            mon_on = 0;
                            check(!mon_bad, cur.tag, int'(got_bits), int'(exp_bits));
                        end
                    end
                end
            end else if (exp_q.size() > 0 &&
                         ((exp_q[0].loop ? loop_line : tx_line) == 1'b0)) begin
                cur = exp_q.pop_front();
                compose(cur, exp_bits, nb_cur);
                for (int i = nb_cur; i < 32; i++) exp_bits[i] = 1'b1;
                got_bits = '1;
                mon_bad = 0;
                tcount = 0;
                sample_bit(0);
                mon_on = 1;
            end
        end
        rc = (rc == REF_DIV - 1) ? 0 : rc + 1;
        ref_tick = (rc == 0);
    end

    // Offer a word, wait for its pop, and record the settings captured there (R7, R8)
    task automatic push_word(input logic [15:0] d, input string tag);
        item_t it;
        fifo_data  = d;
        fifo_valid = 1;
        #1;
        while (!fifo_pop) begin
            @(negedge clk);
            #1;
        end
        it.data = d;
        it.lcr  = line_ctrl;
        it.div  = (divisor == 0) ? 1 : int'(divisor);
        it.loop = loop_sel;
        it.tag  = tag;
        exp_q.push_back(it);
        @(negedge clk);
        fifo_valid = 0;
    endtask

    task automatic wait_drain();
        do @(negedge clk); while (!(exp_q.size() == 0 && !mon_on && all_empty));
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog actual=%0d expected=0", exp_q.size());
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R1: line idles high after reset
        check(tx_line === 1'b1 && loop_line === 1'b1, "R1 idle lines", {tx_line, loop_line}, 2'b11);
        // R10: both flags set after reset, and no pop without a word
        check(thr_empty === 1'b1 && all_empty === 1'b1 && fifo_pop === 1'b0,
              "R10 reset flags", {thr_empty, all_empty, fifo_pop}, 3'b110);
        @(negedge clk);

        // R2 R6: 8 data bits, no parity, one stop bit, divisor 1
        line_ctrl = mk_lcr(8, 0, 3'd0, 0);
        divisor = 16'd1;
        push_word(16'h00A5, "R2 R6 8N1 frame");
        #1;
        // R10: slot empty but frame running
        check(thr_empty === 1'b1 && all_empty === 1'b0, "R10 flags mid-frame",
              {thr_empty, all_empty}, 2'b10);
        // R8: reprogram during the frame; the running frame keeps the old settings
        line_ctrl = mk_lcr(3, 0, 3'd1, 0);
        divisor = 16'd2;
        fifo_data = 16'h01F3;
        fifo_valid = 1;
        #1;
        // R7: no pop while busy, and thr_empty follows fifo_valid
        check(fifo_pop === 1'b0 && thr_empty === 1'b0 && all_empty === 1'b0,
              "R7 R10 no pop while busy", {fifo_pop, thr_empty, all_empty}, 3'b000);
        @(negedge clk);
        // R3 R5 R6: length field 3 gives 5 bits, odd parity, divisor 2
        push_word(16'h01F3, "R3 R5 R8 short odd frame");
        wait_drain();
        #1;
        check(all_empty === 1'b1 && tx_line === 1'b1, "R1 R10 idle after frames",
              {all_empty, tx_line}, 2'b11);

        // R3 R4 R5: length field 0 gives 16 bits, even parity, two stop bits, divisor 3
        line_ctrl = mk_lcr(0, 1, 3'd2, 0);
        divisor = 16'd3;
        push_word(16'hBEEF, "R3 R4 R5 full word even");
        wait_drain();

        // R5 R6: mark parity, 7 bits, divisor 0 counts as 1
        line_ctrl = mk_lcr(7, 0, 3'd5, 0);
        divisor = 16'd0;
        push_word(16'hFF55, "R5 R6 mark div0");
        wait_drain();

        // R5: space, reserved code, odd with two stops, sent back to back (R7)
        line_ctrl = mk_lcr(12, 0, 3'd7, 0);
        divisor = 16'd1;
        push_word(16'h0ABC, "R5 space 12 bits");
        line_ctrl = mk_lcr(9, 0, 3'd3, 0);
        push_word(16'h01A5, "R5 reserved code no parity");
        line_ctrl = mk_lcr(15, 1, 3'd1, 0);
        divisor = 16'd2;
        push_word(16'h7FFF, "R4 R5 R7 15 bits odd");
        wait_drain();

        // R9: break forces the external line low while idle
        line_ctrl = mk_lcr(8, 0, 3'd0, 1);
        #1;
        check(tx_line === 1'b0 && loop_line === 1'b1, "R9 break external",
              {tx_line, loop_line}, 2'b01);
        @(negedge clk);
        line_ctrl = mk_lcr(8, 0, 3'd0, 0);
        #1;
        check(tx_line === 1'b1, "R9 break released", tx_line, 1);
        @(negedge clk);

        // R11: loopback carries the frame internally; break follows it there
        loop_sel = 1;
        line_ctrl = mk_lcr(8, 0, 3'd0, 1);
        #1;
        check(loop_line === 1'b0 && tx_line === 1'b1, "R9 R11 break in loopback",
              {tx_line, loop_line}, 2'b10);
        @(negedge clk);
        line_ctrl = mk_lcr(6, 0, 3'd2, 0);
        divisor = 16'd2;
        push_word(16'h003C, "R11 loopback frame");
        wait_drain();
        loop_sel = 0;
        @(negedge clk);
        #1;
        check(tx_line === 1'b1 && loop_line === 1'b1 && all_empty === 1'b1,
              "R1 R11 idle after loopback", {tx_line, loop_line, all_empty}, 3'b111);

        // R3 R2: length field 4 clamps to 5, upper word bits not sent
        line_ctrl = mk_lcr(4, 0, 3'd0, 0);
        divisor = 16'd1;
        push_word(16'hFFE0, "R3 clamp to five");
        wait_drain();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule